// File: doc/BRIEF.md
# Platform Sleep-State Controller

This block is a synchronous state machine that follows the power state of a small platform: processor running (C0), processor halted in a low-power level (C2), suspend-to-memory (S3), suspend-to-storage (S4), soft-off (S5) and mechanical-off (G3). Software drives it through a sleep-control register. The register holds a sleep-type field and a self-clearing sleep-enable bit. A read strobe for the processor's level-2 register also reaches the block. Platform logic supplies break interrupts, a power-button override pulse, a resume-well failure flag, a main power-good level, wake events and a configuration bit that selects the state after a power loss.

From the current state the block drives the enables for the core, suspend and RTC power wells. It also drives a memory self-refresh request, an external-clock enable and a three-bit state code. Every return to C0 from an off state goes through a fixed wake window. During that window the core well is already powered and the external clocks are still stopped. This gives the core well time to settle before clocks start. Power loss has priority over every other event.

Top module: `sleep_state_ctrl`

## Requirements
- R1: While reset is asserted and for as long as power stays lost afterwards, the state code is G3 (7). In G3 only `rtc_well_en` is 1.
- R2: A `lvl2_rd` pulse in C0 (code 0) moves the state to C2 (code 1) at the next clock edge, unless a higher-priority event is present in the same cycle.
- R3: In C2, a `brk_msi` or `brk_irq` pulse returns the state to C0 at the next edge.
- R4: A register write with `ctl_wr_go`=1 takes effect at the second edge, counted from the edge that samples the write, and only while the state is C0. The sleep-type value selects the target: 3'b101 gives S3 (code 3), 3'b110 gives S4 (code 4) and 3'b111 gives S5 (code 5). Any other value leaves the state in C0. In every state other than C0, the sleep-enable bit is ignored.
- R5: `ctl_rdata[2:0]` reads back the last sleep-type value written. `ctl_rdata[3]`, the sleep-enable bit, always reads 0. The internal enable bit clears itself one cycle after it is set.
- R6: A `pwrbtn_ovr` pulse in C0 or C2 forces S5 at the next edge. It has priority over sleep-enable, `lvl2_rd` and break events.
- R7: Power loss forces G3 at the next edge from any state, with priority over all other events. Power loss means `main_pwr_ok`=0 or `rsm_pwr_fail`=1.
- R8: Outputs by state, given as {core, suspend, RTC, self-refresh, clock}:
  - C0 and C2: 11101
  - wake window: 11100
  - S3: 01110
  - S4 and S5: 01100
  - G3: 00100
- R9: A `wake_evt` in S3, S4 or S5 enters the wake window (code 2) at the next edge. The state stays there for 8 cycles and then becomes C0. The core well is on for the whole window, and the external clock turns on only when C0 is reached.
- R10: In G3, wake events are ignored and the state stays G3 while power remains lost.
- R11: When power returns in G3, the next state depends on `cfg_g3_off` and on the state before G3. If `cfg_g3_off`=1, the next state is S5. If `cfg_g3_off`=0 and the state before G3 was C0 or C2, the next state is the wake window. In every other case the next state is S5. After reset, the state before G3 counts as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the sleep-control register |
| ctl_wr_type | input | 3 | Sleep-type value to write |
| ctl_wr_go | input | 1 | Sleep-enable value to write |
| ctl_rdata | output | 4 | Register readback: bit 3 is the enable bit (always 0), bits 2:0 are the sleep type |
| lvl2_rd | input | 1 | Pulse: processor level-2 register read |
| brk_msi | input | 1 | Pulse: message-signalled interrupt break event |
| brk_irq | input | 1 | Pulse: legacy interrupt break event |
| pwrbtn_ovr | input | 1 | Pulse: power-button override |
| rsm_pwr_fail | input | 1 | Resume-well power failure flag |
| main_pwr_ok | input | 1 | Main power-good level |
| wake_evt | input | 1 | Wake event |
| cfg_g3_off | input | 1 | 1: always leave G3 to S5 |
| core_well_en | output | 1 | Core power-well enable |
| sus_well_en | output | 1 | Suspend power-well enable |
| rtc_well_en | output | 1 | RTC power-well enable |
| mem_selfref | output | 1 | Memory self-refresh request |
| ext_clk_en | output | 1 | External clock enable |
| state_code | output | 3 | Current state code |

## Verification
The assertions assume that every event input is synchronous to `clk` and that power-good and resume-fail are already synchronized levels. They also assume that a power-loss condition may arrive on any cycle, in any state, together with any other event. The stimulus drives all inputs at the falling edge. It combines pulse events at random densities, which often places override, break, level-2 and sleep writes in the same cycle. Power drops are short and rare, and `cfg_g3_off` toggles at random, so every G3 recovery branch is reached from both running and sleeping states.

// File: rtl/slp_state_pkg.sv
package slp_state_pkg;

   typedef enum logic [2:0] {
      ST_C0   = 3'd0,
      ST_C2   = 3'd1,
      ST_WAKE = 3'd2,
      ST_S3   = 3'd3,
      ST_S4   = 3'd4,
      ST_S5   = 3'd5,
      ST_G3   = 3'd7
   } pstate_e;

   typedef struct packed {
      logic core;
      logic sus;
      logic rtc;
      logic selfref;
      logic clk;
   } well_s;

   localparam well_s WELLS_G3 = '{core: 1'b0, sus: 1'b0, rtc: 1'b1, selfref: 1'b0, clk: 1'b0};

endpackage

// File: rtl/slp_ctl_regs.sv
module slp_ctl_regs #(
   parameter int TYPE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [TYPE_W-1:0] wr_type,
   input  logic              wr_go,
   output logic [TYPE_W-1:0] type_q,
   output logic              go_q,
   output logic [TYPE_W:0]   rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q <= '0;
         go_q   <= 1'b0;
      end else begin
         go_q <= wr_stb && wr_go;
         if (wr_stb) type_q <= wr_type;
      end
   end

   // enable bit never visible to software
   assign rdata = {1'b0, type_q};

   // R5: enable bit lasts one cycle unless rewritten
   p_go_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_q && !(wr_stb && wr_go)) |=> !go_q);

   // R5: type field holds without a write
   p_type_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(type_q));

endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
   parameter int WAKE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int CNT_W = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run)       cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == LAST);

   // R9: the window starts counting from zero
   p_wake_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/slp_state_fsm.sv
module slp_state_fsm
   import slp_state_pkg::*;
#(
   parameter int TYPE_W  = 3,
   parameter int S3_CODE = 5,
   parameter int S4_CODE = 6,
   parameter int S5_CODE = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_lost,
   input  logic              ovr,
   input  logic              brk,
   input  logic              lvl2,
   input  logic              go,
   input  logic [TYPE_W-1:0] slp_type,
   input  logic              wake,
   input  logic              wake_done,
   input  logic              cfg_g3_off,
   output pstate_e           st_q
);

   localparam logic [TYPE_W-1:0] TY_S3 = TYPE_W'(S3_CODE);
   localparam logic [TYPE_W-1:0] TY_S4 = TYPE_W'(S4_CODE);
   localparam logic [TYPE_W-1:0] TY_S5 = TYPE_W'(S5_CODE);

   pstate_e nxt;
   pstate_e slp_tgt;
   logic    slp_ok;
   logic    was_run_q;

   always_comb begin
      slp_ok  = 1'b1;
      slp_tgt = ST_C0;
      if      (slp_type == TY_S3) slp_tgt = ST_S3;
      else if (slp_type == TY_S4) slp_tgt = ST_S4;
      else if (slp_type == TY_S5) slp_tgt = ST_S5;
      else                        slp_ok  = 1'b0;
   end

   always_comb begin
      nxt = st_q;
      case (st_q)
         ST_C0: begin
            if (ovr)               nxt = ST_S5;
            else if (go && slp_ok) nxt = slp_tgt;
            else if (lvl2)         nxt = ST_C2;
         end
         ST_C2: begin
            if (ovr)      nxt = ST_S5;
            else if (brk) nxt = ST_C0;
         end
         ST_S3, ST_S4, ST_S5: begin
            if (wake) nxt = ST_WAKE;
         end
         ST_WAKE: begin
            if (wake_done) nxt = ST_C0;
         end
         ST_G3: begin
            if (!pwr_lost) nxt = (cfg_g3_off || !was_run_q) ? ST_S5 : ST_WAKE;
         end
         default: nxt = ST_G3;
      endcase
      if (pwr_lost) nxt = ST_G3;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_G3;
         was_run_q <= 1'b0;
      end else begin
         st_q <= nxt;
         if (st_q != ST_G3 && nxt == ST_G3)
            was_run_q <= (st_q == ST_C0) || (st_q == ST_C2);
      end
   end

   // R7: power loss wins from any state
   p_lost_g3_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_lost |=> (st_q == ST_G3));

   // R6: override forces soft-off from C0/C2
   p_ovr_s5_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_lost && ovr && (st_q == ST_C0 || st_q == ST_C2)) |=> (st_q == ST_S5));

   // R3: break leaves C2
   p_brk_c0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_lost && !ovr && brk && st_q == ST_C2) |=> (st_q == ST_C0));

   // R2: level-2 read enters C2
   p_lvl2_c2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_lost && !ovr && !go && lvl2 && st_q == ST_C0) |=> (st_q == ST_C2));

   // R9: wake from a sleep state enters the window
   p_wake_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_lost && wake && (st_q == ST_S3 || st_q == ST_S4 || st_q == ST_S5))
      |=> (st_q == ST_WAKE));

   // R10: G3 never jumps straight to C0 or a sleep-enable target
   p_g3_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_G3) |=> (st_q == ST_G3 || st_q == ST_S5 || st_q == ST_WAKE));

   // R11: configuration bit sends recovery to soft-off
   p_g3_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_G3 && !pwr_lost && cfg_g3_off) |=> (st_q == ST_S5));

   // R4: sleep-enable outside C0 has no effect on a sleep state
   p_go_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_lost && !wake && go && (st_q == ST_S3 || st_q == ST_S4)) |=> $stable(st_q));

endmodule

// File: rtl/slp_well_decode.sv
module slp_well_decode
   import slp_state_pkg::*;
(
   input  pstate_e st,
   output well_s   wells
);

   always_comb begin
      wells = WELLS_G3;
      case (st)
         ST_C0, ST_C2: wells = '{core: 1'b1, sus: 1'b1, rtc: 1'b1, selfref: 1'b0, clk: 1'b1};
         ST_WAKE:      wells = '{core: 1'b1, sus: 1'b1, rtc: 1'b1, selfref: 1'b0, clk: 1'b0};
         ST_S3:        wells = '{core: 1'b0, sus: 1'b1, rtc: 1'b1, selfref: 1'b1, clk: 1'b0};
         ST_S4, ST_S5: wells = '{core: 1'b0, sus: 1'b1, rtc: 1'b1, selfref: 1'b0, clk: 1'b0};
         default:      wells = WELLS_G3;
      endcase
   end

endmodule

// File: rtl/sleep_state_ctrl.sv
module sleep_state_ctrl
   import slp_state_pkg::*;
#(
   parameter int TYPE_W   = 3,
   parameter int S3_CODE  = 5,
   parameter int S4_CODE  = 6,
   parameter int S5_CODE  = 7,
   parameter int WAKE_CYC = 8,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [TYPE_W-1:0] ctl_wr_type,
   input  logic              ctl_wr_go,
   output logic [TYPE_W:0]   ctl_rdata,
   input  logic              lvl2_rd,
   input  logic              brk_msi,
   input  logic              brk_irq,
   input  logic              pwrbtn_ovr,
   input  logic              rsm_pwr_fail,
   input  logic              main_pwr_ok,
   input  logic              wake_evt,
   input  logic              cfg_g3_off,
   output logic              core_well_en,
   output logic              sus_well_en,
   output logic              rtc_well_en,
   output logic              mem_selfref,
   output logic              ext_clk_en,
   output logic [2:0]        state_code
);

   localparam int TYPE_SPAN = 1 << TYPE_W;

   if (TYPE_W < 1 || TYPE_W > 8) begin : g_bad_width
      $error("sleep_state_ctrl: TYPE_W out of range");
   end
   if (S3_CODE >= TYPE_SPAN || S4_CODE >= TYPE_SPAN || S5_CODE >= TYPE_SPAN) begin : g_bad_code
      $error("sleep_state_ctrl: sleep-type code does not fit TYPE_W");
   end
   if (S3_CODE == S4_CODE || S3_CODE == S5_CODE || S4_CODE == S5_CODE) begin : g_dup_code
      $error("sleep_state_ctrl: sleep-type codes must differ");
   end
   if (WAKE_CYC < 2) begin : g_bad_wake
      $error("sleep_state_ctrl: WAKE_CYC must be at least 2");
   end

   logic [TYPE_W-1:0] type_q;
   logic              go_q;
   logic              pwr_lost;
   logic              wake_done;
   pstate_e           st_q;
   well_s             wells_c;
   well_s             wells_o;

   assign pwr_lost = !main_pwr_ok || rsm_pwr_fail;

   slp_ctl_regs #(.TYPE_W(TYPE_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (ctl_wr),
      .wr_type (ctl_wr_type),
      .wr_go   (ctl_wr_go),
      .type_q  (type_q),
      .go_q    (go_q),
      .rdata   (ctl_rdata)
   );

   slp_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == ST_WAKE),
      .done  (wake_done)
   );

   slp_state_fsm #(
      .TYPE_W  (TYPE_W),
      .S3_CODE (S3_CODE),
      .S4_CODE (S4_CODE),
      .S5_CODE (S5_CODE)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_lost   (pwr_lost),
      .ovr        (pwrbtn_ovr),
      .brk        (brk_msi || brk_irq),
      .lvl2       (lvl2_rd),
      .go         (go_q),
      .slp_type   (type_q),
      .wake       (wake_evt),
      .wake_done  (wake_done),
      .cfg_g3_off (cfg_g3_off),
      .st_q       (st_q)
   );

   slp_well_decode u_dec (
      .st    (st_q),
      .wells (wells_c)
   );

   if (OUT_REG) begin : g_out_reg
      logic [2:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wells_o <= WELLS_G3;
            code_q  <= 3'(ST_G3);
         end else begin
            wells_o <= wells_c;
            code_q  <= 3'(st_q);
         end
      end
      assign state_code = code_q;
   end else begin : g_out_comb
      assign wells_o    = wells_c;
      assign state_code = 3'(st_q);
   end

   assign core_well_en = wells_o.core;
   assign sus_well_en  = wells_o.sus;
   assign rtc_well_en  = wells_o.rtc;
   assign mem_selfref  = wells_o.selfref;
   assign ext_clk_en   = wells_o.clk;

   // R9: clocks start only after the core well was already on
   p_core_before_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_clk_en) |-> $past(core_well_en));

   // R8: self-refresh only with clocks stopped
   p_selfref_noclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_selfref |-> (!ext_clk_en && !core_well_en));

   // R8: core well implies suspend well
   p_core_needs_sus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      core_well_en |-> sus_well_en);

   // R5: enable bit invisible on readback
   p_rd_go_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> !ctl_rdata[TYPE_W]);

endmodule

// File: tb/sleep_state_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_state_ctrl_tb;

   localparam int WAKE = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 0, ctl_wr_go = 0;
   logic [2:0] ctl_wr_type = 0;
   logic [3:0] ctl_rdata;
   logic       lvl2_rd = 0, brk_msi = 0, brk_irq = 0, pwrbtn_ovr = 0;
   logic       rsm_pwr_fail = 0, main_pwr_ok = 0, wake_evt = 0, cfg_g3_off = 0;
   logic       core_well_en, sus_well_en, rtc_well_en, mem_selfref, ext_clk_en;
   logic [2:0] state_code;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   // bench-side model of the requirements
   int       m_st = 7, m_cnt = 0;
   bit       m_go = 0, m_was0 = 0;
   bit [2:0] m_type = 0;

   always #4 clk = ~clk;

   sleep_state_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wr_type(ctl_wr_type),
      .ctl_wr_go(ctl_wr_go), .ctl_rdata(ctl_rdata), .lvl2_rd(lvl2_rd),
      .brk_msi(brk_msi), .brk_irq(brk_irq), .pwrbtn_ovr(pwrbtn_ovr),
      .rsm_pwr_fail(rsm_pwr_fail), .main_pwr_ok(main_pwr_ok), .wake_evt(wake_evt),
      .cfg_g3_off(cfg_g3_off), .core_well_en(core_well_en), .sus_well_en(sus_well_en),
      .rtc_well_en(rtc_well_en), .mem_selfref(mem_selfref), .ext_clk_en(ext_clk_en),
      .state_code(state_code));

   // R8 table: {core, sus, rtc, selfref, clk}
   function automatic logic [4:0] wells_of(int s);
      case (s)
         0, 1:    return 5'b11101;
         2:       return 5'b11100;
         3:       return 5'b01110;
         4, 5:    return 5'b01100;
         default: return 5'b00100;
      endcase
   endfunction

   // R4 sleep-type codes
   function automatic int slp_target(bit [2:0] t);
      case (t)
         3'b101:  return 3;
         3'b110:  return 4;
         3'b111:  return 5;
         default: return 0;
      endcase
   endfunction

   task automatic model_edge();
      bit lost = !main_pwr_ok || rsm_pwr_fail;
      int n = m_st;
      case (m_st)
         0: if (pwrbtn_ovr) n = 5;
            else if (m_go && slp_target(m_type) != 0) n = slp_target(m_type);
            else if (lvl2_rd) n = 1;
         1: if (pwrbtn_ovr) n = 5; else if (brk_msi || brk_irq) n = 0;
         3, 4, 5: if (wake_evt) n = 2;
         2: if (m_cnt == WAKE - 1) n = 0;
         7: if (!lost) n = (cfg_g3_off || !m_was0) ? 5 : 2;
         default: n = 7;
      endcase
      if (lost) n = 7;
      if (m_st != 7 && n == 7) m_was0 = (m_st <= 1);
      m_cnt = (m_st == 2 && n == 2) ? m_cnt + 1 : 0;
      m_st = n;
      m_go = ctl_wr && ctl_wr_go;
      if (ctl_wr) m_type = ctl_wr_type;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " state"}, 32'(state_code), 32'(m_st));
      chk({tag, " wells"}, 32'({core_well_en, sus_well_en, rtc_well_en, mem_selfref, ext_clk_en}),
          32'(wells_of(m_st)));
      chk({tag, " rdata R5"}, 32'(ctl_rdata), 32'({1'b0, m_type}));
   endtask

   task automatic clear_pulses();
      ctl_wr = 0; ctl_wr_go = 0; lvl2_rd = 0; brk_msi = 0; brk_irq = 0;
      pwrbtn_ovr = 0; wake_evt = 0; rsm_pwr_fail = 0;
   endtask

   // one clock: inputs already set, model follows edge, compare at negedge
   task automatic cyc(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all(tag);
      clear_pulses();
   endtask

   task automatic expect_code(string tag, int code);
      chk(tag, 32'(state_code), 32'(code));
   endtask

   task automatic do_wake(string tag);
      wake_evt = 1;
      cyc({tag, " R9 enter"});
      expect_code("R9 window code", 2);
      chk("R9 core on clk off", 32'({core_well_en, ext_clk_en}), 32'b10);
      for (int i = 0; i < WAKE - 1; i++) cyc("R9 window");
      expect_code("R9 still in window", 2);
      cyc("R9 exit");
      expect_code("R9 reaches C0", 0);
      chk("R9 clock on in C0", 32'(ext_clk_en), 32'd1);
   endtask

   task automatic sleep_write(bit [2:0] t, bit go);
      ctl_wr = 1; ctl_wr_type = t; ctl_wr_go = go;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h51EE_9A3D));
      // R1: reset with power lost
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      expect_code("R1 reset code G3", 7);
      rst_n = 1;
      cyc("R1 after reset");
      cyc("R10 G3 holds");
      wake_evt = 1;
      cyc("R10 wake ignored in G3");
      expect_code("R10 still G3", 7);
      // R11: first power-up goes to S5
      main_pwr_ok = 1;
      cyc("R11 boot to S5");
      expect_code("R11 boot S5", 5);
      do_wake("boot");
      // R2 / R3
      lvl2_rd = 1; cyc("R2 enter C2"); expect_code("R2 code C2", 1);
      brk_msi = 1; cyc("R3 msi break"); expect_code("R3 back C0 msi", 0);
      lvl2_rd = 1; cyc("R2 again");
      brk_irq = 1; cyc("R3 irq break"); expect_code("R3 back C0 irq", 0);
      // R4: invalid type stays in C0
      sleep_write(3'b010, 1); cyc("R4 write bad type");
      cyc("R4 bad type no effect"); expect_code("R4 stays C0", 0);
      chk("R5 readback type", 32'(ctl_rdata), 32'h2);
      // R4: S3
      sleep_write(3'b101, 1); cyc("R4 write S3");
      expect_code("R4 not yet", 0);
      cyc("R4 enter S3"); expect_code("R4 code S3", 3);
      chk("R8 S3 wells", 32'({core_well_en, sus_well_en, rtc_well_en, mem_selfref, ext_clk_en}), 32'b01110);
      sleep_write(3'b111, 1); cyc("R4 write in S3");
      cyc("R4 ignored in S3"); expect_code("R4 S3 kept", 3);
      do_wake("from S3");
      // R4: write without go only updates type
      sleep_write(3'b110, 0); cyc("R5 type only");
      cyc("R5 no go"); expect_code("R5 no transition", 0);
      // R6: override priority over lvl2 in C0, and override from C2
      pwrbtn_ovr = 1; lvl2_rd = 1; cyc("R6 ovr beats lvl2"); expect_code("R6 S5", 5);
      do_wake("from S5");
      lvl2_rd = 1; cyc("R2 C2 before ovr");
      pwrbtn_ovr = 1; brk_irq = 1; cyc("R6 ovr in C2"); expect_code("R6 S5 from C2", 5);
      do_wake("again");
      // R7 + R11: power loss in C0, recover with cfg=0 -> wake window
      main_pwr_ok = 0; pwrbtn_ovr = 1; cyc("R7 loss beats ovr"); expect_code("R7 G3", 7);
      chk("R1 G3 wells", 32'({core_well_en, sus_well_en, rtc_well_en, mem_selfref, ext_clk_en}), 32'b00100);
      main_pwr_ok = 1; cfg_g3_off = 0; cyc("R11 recover to window"); expect_code("R11 window", 2);
      for (int i = 0; i < WAKE; i++) cyc("R11 window run");
      expect_code("R11 back in C0", 0);
      // R7 from S4, recover -> S5
      sleep_write(3'b110, 1); cyc("R4 write S4"); cyc("R4 enter S4"); expect_code("R4 code S4", 4);
      rsm_pwr_fail = 1; cyc("R7 resume fail in S4"); expect_code("R7 G3 from S4", 7);
      cyc("R11 recover from sleep"); expect_code("R11 S5 after sleep", 5);
      // R11 cfg=1 from C0
      do_wake("pre cfg");
      main_pwr_ok = 0; cyc("R7 loss in C0");
      main_pwr_ok = 1; cfg_g3_off = 1; cyc("R11 cfg forces S5"); expect_code("R11 cfg S5", 5);
      do_wake("post cfg");
      // random phase
      for (int k = 0; k < 4000; k++) begin
         lvl2_rd    = ($urandom % 6) == 0;
         brk_msi    = ($urandom % 7) == 0;
         brk_irq    = ($urandom % 7) == 0;
         pwrbtn_ovr = ($urandom % 40) == 0;
         wake_evt   = ($urandom % 8) == 0;
         rsm_pwr_fail = ($urandom % 250) == 0;
         if (main_pwr_ok) main_pwr_ok = ($urandom % 70) != 0;
         else             main_pwr_ok = ($urandom % 4) == 0;
         if (($urandom % 20) == 0) cfg_g3_off = ~cfg_g3_off;
         if (($urandom % 6) == 0) sleep_write(3'($urandom % 8), 1'($urandom % 2));
         cyc("R8 random");
      end
      finish_run();
   end

endmodule